// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers up to sixteen interrupt request lines in front of a small CPU core and offers the core one request at a time. Each request line sets a pending flag that stays set until the core takes that request or software clears it. Software chooses which sources may be offered. A per-source enable and one global enable do this. A 3-bit urgency value for each source is given as input from a register file outside the block. Software can also set or clear any pending flag directly.

The controller picks one winner from the sources that are pending and unmasked. It raises a valid flag together with the winner's index. When the core takes the request it pulses an acknowledge. The acknowledge clears the winner's pending flag and pushes the winner's urgency onto a small stack of levels in service. An end-of-service pulse pops that stack. Only a source that is strictly more urgent than the level on top of the stack is offered. This lets handlers nest in a controlled way. Fetching the vector and saving registers are the core's job.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle high on a request line sets that source's pending flag on the next clock edge. The flag stays set after the line goes low.
- R2: A pending source is offered only while both its own enable and the global enable are high. A masked source keeps its pending flag and is offered once it is unmasked.
- R3: Among the offered candidates the one with the numerically smallest urgency value wins. Urgency 0 is the most urgent and 7 the least.
- R4: When candidates have equal urgency, the one with the lowest source index wins.
- R5: An acknowledge while the valid flag is high clears the offered source's pending flag at that clock edge. An acknowledge while the valid flag is low has no effect.
- R6: A request or software set on the same source in the same cycle as its acknowledge leaves the pending flag set.
- R7: While the stack is not empty, a candidate is offered only if its urgency value is strictly smaller than the value on top of the stack.
- R8: An end-of-service pulse removes the top stack entry. Offering then resumes against the level below it. If both pulses arrive in the same cycle, the top entry is replaced.
- R9: The stack holds 4 levels. While it is full nothing is offered. An end-of-service pulse on an empty stack has no effect.
- R10: Software set and clear inputs write the pending flags. A clear loses to a set or a request on the same source in the same cycle.
- R11: After reset no flag is pending, the stack is empty and the valid flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronous to clk_i |
| irq_req_i | input | 16 | Request lines, one per source |
| src_en_i | input | 16 | Per-source enable |
| src_prio_i | input | 48 | Urgency values, 3 bits per source, source i at bits [3i+2:3i] |
| glb_en_i | input | 1 | Global enable |
| pend_set_i | input | 16 | Software set of pending flags |
| pend_clr_i | input | 16 | Software clear of pending flags |
| irq_ack_i | input | 1 | Core takes the offered request |
| eoi_i | input | 1 | Core ends the current handler |
| irq_valid_o | output | 1 | A request is offered |
| irq_id_o | output | 4 | Index of the offered source |

## Verification
Directed sequences test each rule in turn. A single request tests latching. Masks are toggled to tell apart gating from loss of pending state. Three sources of different urgency and two sources of equal urgency separate the value rule from the index tie rule. A nesting ladder fills the stack with decreasing values and presents an equal-urgency source and a more urgent one. This shows the strict comparison and the blocking when the stack is full, and then unwinds. Colliding pulses (acknowledge with request, clear with set, acknowledge with end-of-service) and long random traffic are checked on every cycle against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_SWAP = 2'd3
  } stk_op_e;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] sw_set_i,
  input  logic [NSRC-1:0] sw_clr_i,
  input  logic [NSRC-1:0] ack_vec_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q, pend_d;
  logic            upd_en;

  // clears first, then sets win (ack/sw clear lose to request/sw set)
  always_comb begin
    pend_d = (pend_q & ~(ack_vec_i | sw_clr_i)) | req_i | sw_set_i;
    upd_en = |(req_i | sw_set_i | sw_clr_i | ack_vec_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (upd_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_req_latches_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[i] |=> pend_o[i]);
    assert_pend_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[i] && !ack_vec_i[i] && !sw_clr_i[i]) |=> pend_o[i]);
    assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_vec_i[i] && !req_i[i] && !sw_set_i[i]) |=> !pend_o[i]);
    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_set_i[i] && sw_clr_i[i]) |=> pend_o[i]);
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NSRC = 16,
  parameter int PW   = 3,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]    cand_i,
  input  logic [NSRC*PW-1:0] prio_i,
  output logic               any_o,
  output logic [IDW-1:0]     id_o,
  output logic [PW-1:0]      prio_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    any_o  = 1'b0;
    id_o   = '0;
    prio_o = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_i[i] && (!any_o || (prio_i[i*PW +: PW] < prio_o))) begin
        any_o  = 1'b1;
        id_o   = IDW'(i);
        prio_o = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack
  import irqc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [PW-1:0] push_prio_i,
  output logic          empty_o,
  output logic          full_o,
  output logic [PW-1:0] top_o
);
  logic [PW-1:0] stk_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, wr_en;
  logic [AW-1:0] wr_idx, top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign top_idx = AW'(cnt_q - CW'(1));
  assign top_o   = empty_o ? '0 : stk_q[top_idx];

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    wr_en  = 1'b0;
    wr_idx = top_idx;
    unique case (op_i)
      STK_PUSH: begin
        cnt_d  = cnt_q + CW'(1);
        cnt_en = 1'b1;
        wr_en  = 1'b1;
        wr_idx = AW'(cnt_q);
      end
      STK_POP: begin
        cnt_d  = cnt_q - CW'(1);
        cnt_en = 1'b1;
      end
      STK_SWAP: wr_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) stk_q[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++)
        if (wr_en && (wr_idx == AW'(e))) stk_q[e] <= push_prio_i;
    end
  end

  assert_depth_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_no_push_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == STK_PUSH) |-> !full_o);
  assert_pop_nonempty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == STK_POP || op_i == STK_SWAP) |-> !empty_o);
  assert_push_visible_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == STK_PUSH || op_i == STK_SWAP) |=> (top_o == $past(push_prio_i)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int PW    = 3,
  parameter int DEPTH = 4,
  localparam int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NSRC-1:0]    irq_req_i,
  input  logic [NSRC-1:0]    src_en_i,
  input  logic [NSRC*PW-1:0] src_prio_i,
  input  logic               glb_en_i,
  input  logic [NSRC-1:0]    pend_set_i,
  input  logic [NSRC-1:0]    pend_clr_i,
  input  logic               irq_ack_i,
  input  logic               eoi_i,
  output logic               irq_valid_o,
  output logic [IDW-1:0]     irq_id_o
);
  logic [NSRC-1:0] pend, cand, ack_vec;
  logic            win_any, preempt_ok, ack_ok, pop_ok;
  logic [PW-1:0]   win_prio, stk_top;
  logic            stk_empty, stk_full;
  stk_op_e         stk_op;

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (irq_req_i),
    .sw_set_i  (pend_set_i),
    .sw_clr_i  (pend_clr_i),
    .ack_vec_i (ack_vec),
    .pend_o    (pend)
  );

  assign cand = pend & src_en_i & {NSRC{glb_en_i}};

  irqc_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .cand_i (cand),
    .prio_i (src_prio_i),
    .any_o  (win_any),
    .id_o   (irq_id_o),
    .prio_o (win_prio)
  );

  always_comb begin
    preempt_ok  = !stk_full && (stk_empty || (win_prio < stk_top));
    irq_valid_o = win_any && preempt_ok;
    ack_ok      = irq_ack_i && irq_valid_o;
    pop_ok      = eoi_i && !stk_empty;
    ack_vec     = '0;
    if (ack_ok) ack_vec[irq_id_o] = 1'b1;
    unique case ({ack_ok, pop_ok})
      2'b10:   stk_op = STK_PUSH;
      2'b01:   stk_op = STK_POP;
      2'b11:   stk_op = STK_SWAP;
      default: stk_op = STK_HOLD;
    endcase
  end

  irqc_prio_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (stk_op),
    .push_prio_i (win_prio),
    .empty_o     (stk_empty),
    .full_o      (stk_full),
    .top_o       (stk_top)
  );

  assert_valid_qualified_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (pend[irq_id_o] && src_en_i[irq_id_o] && glb_en_i));
  assert_preempt_strict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && !stk_empty) |-> (win_prio < stk_top));
  assert_full_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_full |-> !irq_valid_o);
  assert_winner_prio_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (win_prio == src_prio_i[irq_id_o*PW +: PW]));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int NS = 16;
  localparam int PW = 3;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] req, en, set_v, clr_v;
  logic [PW-1:0] prio_a [NS];
  logic [NS*PW-1:0] prio_flat;
  logic          glb, ack, eoi;
  logic          valid;
  logic [3:0]    id;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit mpend [NS];
  int mstk [$];
  bit e_valid;
  int e_id;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NS; i++) prio_flat[i*PW +: PW] = prio_a[i];

  prio_irq_ctrl #(.NSRC(NS), .PW(PW), .DEPTH(DP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .src_en_i(en),
    .src_prio_i(prio_flat), .glb_en_i(glb), .pend_set_i(set_v),
    .pend_clr_i(clr_v), .irq_ack_i(ack), .eoi_i(eoi),
    .irq_valid_o(valid), .irq_id_o(id)
  );

  task automatic model_arb();
    int best = -1;
    for (int i = 0; i < NS; i++)
      if (mpend[i] && en[i] && glb && (best < 0 || prio_a[i] < prio_a[best])) best = i;
    e_id = best;
    e_valid = (best >= 0) && (mstk.size() < DP) &&
              (mstk.size() == 0 || int'(prio_a[best]) < mstk[$]);
  endtask

  task automatic model_step();
    bit ackd, popd;
    model_arb();
    ackd = ack && e_valid;
    popd = eoi && (mstk.size() > 0);
    for (int i = 0; i < NS; i++) begin
      if ((ackd && e_id == i) || clr_v[i]) mpend[i] = 0;
      if (req[i] || set_v[i]) mpend[i] = 1;
    end
    if (popd) void'(mstk.pop_back());
    if (ackd) mstk.push_back(int'(prio_a[e_id]));
  endtask

  task automatic compare(string tag);
    model_arb();
    n_chk++;
    if (valid !== e_valid || (e_valid && id !== 4'(e_id))) begin
      n_fail++;
      $display("FAIL %s: valid/id actual %0b/%0d expected %0b/%0d", tag, valid, id, e_valid, e_id);
    end
  endtask

  task automatic expect_out(string tag, bit v, int i);
    n_chk++;
    if (valid !== v || (v && id !== 4'(i))) begin
      n_fail++;
      $display("FAIL %s: valid/id actual %0b/%0d expected %0b/%0d", tag, valid, id, v, i);
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
    req = '0; set_v = '0; clr_v = '0; ack = 0; eoi = 0;
  endtask

  task automatic pulse_req(int s, string tag);
    req[s] = 1'b1;
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req = '0; en = '1; set_v = '0; clr_v = '0; glb = 1; ack = 0; eoi = 0;
    for (int i = 0; i < NS; i++) begin prio_a[i] = 3'(i % 8); mpend[i] = 0; end
    repeat (3) @(negedge clk);
    expect_out("R11", 0, 0);
    rst_n = 1;
    cycle("R11");
    expect_out("R11", 0, 0);

    // R1: latch and hold
    pulse_req(3, "R1");
    expect_out("R1", 1, 3);
    repeat (3) cycle("R1");
    expect_out("R1", 1, 3);

    // R2: masks
    en[3] = 0; cycle("R2"); expect_out("R2", 0, 0);
    en[3] = 1; glb = 0; cycle("R2"); expect_out("R2", 0, 0);
    glb = 1; cycle("R2"); expect_out("R2", 1, 3);

    // R5: ack clears, then eoi empties stack
    ack = 1; cycle("R5"); expect_out("R5", 0, 0);
    eoi = 1; cycle("R8");
    ack = 1; cycle("R5");             // ack while nothing offered
    pulse_req(6, "R5"); expect_out("R5", 1, 6);
    ack = 1; cycle("R5"); eoi = 1; cycle("R8");

    // R3 / R4: selection
    prio_a[7] = 1; prio_a[2] = 5; prio_a[10] = 0;
    req[7] = 1; req[2] = 1; req[10] = 1; cycle("R3");
    expect_out("R3", 1, 10);
    clr_v = '1; cycle("R10"); expect_out("R10", 0, 0);
    prio_a[4] = 2; prio_a[9] = 2; prio_a[1] = 6;
    req[9] = 1; req[4] = 1; req[1] = 1; cycle("R4");
    expect_out("R4", 1, 4);
    clr_v = '1; cycle("R10");

    // R7 / R9 / R8: nesting ladder
    prio_a[1] = 6; prio_a[2] = 6; prio_a[5] = 5; prio_a[6] = 4; prio_a[8] = 3; prio_a[11] = 1;
    pulse_req(1, "R7"); ack = 1; cycle("R7");
    pulse_req(2, "R7"); expect_out("R7", 0, 0);
    pulse_req(5, "R7"); expect_out("R7", 1, 5); ack = 1; cycle("R7");
    pulse_req(6, "R7"); ack = 1; cycle("R7");
    pulse_req(8, "R7"); ack = 1; cycle("R9");
    pulse_req(11, "R9"); expect_out("R9", 0, 0);
    eoi = 1; cycle("R8"); expect_out("R8", 1, 11);
    ack = 1; eoi = 1; cycle("R8");      // swap
    repeat (4) begin eoi = 1; cycle("R8"); end
    expect_out("R8", 1, 2);
    ack = 1; cycle("R8");
    repeat (3) begin eoi = 1; cycle("R9"); end  // extra eoi on empty ignored
    pulse_req(15, "R9"); expect_out("R9", 1, 15);

    // R6: request colliding with ack
    req[15] = 1; ack = 1; cycle("R6");
    eoi = 1; cycle("R6"); expect_out("R6", 1, 15);
    clr_v = '1; cycle("R10");

    // R10: software set / clear
    set_v[12] = 1; cycle("R10"); expect_out("R10", 1, 12);
    clr_v[12] = 1; cycle("R10"); expect_out("R10", 0, 0);
    clr_v[12] = 1; set_v[12] = 1; cycle("R10"); expect_out("R10", 1, 12);
    clr_v[12] = 1; req[12] = 1; cycle("R10"); expect_out("R10", 1, 12);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0)
        for (int i = 0; i < NS; i++) prio_a[i] = 3'($urandom_range(0, 7));
      req   = NS'($urandom) & NS'($urandom) & NS'($urandom);
      set_v = ($urandom_range(0, 9) == 0) ? NS'($urandom) & NS'($urandom) : '0;
      clr_v = ($urandom_range(0, 5) == 0) ? NS'($urandom) : '0;
      en    = NS'($urandom) | NS'($urandom);
      glb   = ($urandom_range(0, 9) != 0);
      ack   = $urandom_range(0, 2) == 0;
      eoi   = $urandom_range(0, 3) == 0;
      cycle("R3/R7/R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule